// File: doc/BRIEF.md
# Prioritised Pin Output Arbiter

This block merges pin-write requests from four small I/O sequencers onto one shared bank of pin value and pin direction registers. In any cycle each sequencer can present a data write (an OUT-style or SET-style write) and a side-set write. Each write carries a base pin and a pin count, and together they form a contiguous pin mask that wraps around the top of the bank. When several writes touch the same pin in one cycle, a fixed priority decides the result, and the winning values are registered on the next clock edge.

Each sequencer has a small set of options that are loaded by a strobe. A sticky option makes the sequencer drive its latest data write again on every cycle. An inline-enable option takes one bit of OUT data, chosen by an index, and uses it as a per-write enable. A direction option routes side-set data into the pin direction register instead of the pin value register. When sticky and inline-enable are both set, an OUT write whose enable bit is 0 withdraws the sequencer's stored write. Lower-priority sequencers then show through, which lets a higher-priority sequencer mask or override them.

Top module: `pin_out_arbiter`

## Requirements
- R1: During reset and after it, `pin_val` and `pin_dir` are all zeros, and every sequencer's options (sticky, inline enable, side-set direction, enable index) are 0.
- R2: A write affects only the pins in its mask. The mask starts at pin `base` and covers `count` pins upward, wrapping from pin 31 to pin 0. A count of 0 selects no pin and a count of 32 or more selects all pins. A pin with no active request keeps its registered value and direction.
- R3: When several sequencers write the same pin of the same register in one cycle, the highest-numbered sequencer wins (sequencer 3 over 2 over 1 over 0).
- R4: A sequencer's side-set write takes precedence over its own data write to the same pin of the same register in the same cycle.
- R5: With the side-set direction option at 1, side-set data goes to `pin_dir` and leaves `pin_val` untouched. With the option at 0, side-set data goes to `pin_val`. Data writes always target `pin_val`.
- R6: With the sticky option at 1, the sequencer's most recent accepted data write (mask and data) is presented again on every cycle in which that sequencer issues no data write.
- R7: With the inline-enable option at 1, an OUT write (`dw_is_out`=1) whose data bit at the configured index is 0 is dropped. SET writes (`dw_is_out`=0) ignore the enable bit.
- R8: With sticky and inline enable both at 1, a dropped OUT write also cancels the stored sticky write, so lower-priority sequencers' writes to those pins take effect.
- R9: A `cfg_load` strobe loads the sequencer's options at the clock edge and clears its stored sticky write. Writes issued in that same cycle use the old options.
- R10: Outputs are registered. A request presented before a rising edge appears on `pin_val`/`pin_dir` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 4 | Per-sequencer option load strobe |
| cfg_sticky | input | 4 | Sticky option value to load |
| cfg_inl_en | input | 4 | Inline-enable option value to load |
| cfg_side_dir | input | 4 | Side-set-to-direction option value to load |
| cfg_en_idx | input | 20 | Enable-bit index to load, 5 bits per sequencer |
| dw_valid | input | 4 | Data write request per sequencer |
| dw_is_out | input | 4 | 1 = OUT-style write, 0 = SET-style write |
| dw_base | input | 20 | Data write base pin, 5 bits per sequencer |
| dw_count | input | 24 | Data write pin count, 6 bits per sequencer |
| dw_data | input | 128 | Data write values aligned to pins, 32 bits per sequencer |
| ss_valid | input | 4 | Side-set write request per sequencer |
| ss_base | input | 20 | Side-set base pin, 5 bits per sequencer |
| ss_count | input | 24 | Side-set pin count, 6 bits per sequencer |
| ss_data | input | 128 | Side-set values aligned to pins, 32 bits per sequencer |
| pin_val | output | 32 | Registered pin values |
| pin_dir | output | 32 | Registered pin directions |

## Verification
Every write request lands on `pin_val`/`pin_dir` one rising edge after it is presented. A `cfg_load` changes behaviour only for requests presented from the following cycle onward. The bench applies inputs on the falling edge and advances its reference model for the coming rising edge. It compares both outputs at the next falling edge, so every result is sampled exactly one edge after its stimulus. Sticky effects are observed over several later cycles, with the stimulus cleared between them, and each cycle is compared separately.

// File: rtl/pinarb_pkg.sv
package pinarb_pkg;
  localparam int DEF_NUM_SEQ  = 4;
  localparam int DEF_NUM_PINS = 32;

  // write flavours for the data path
  typedef enum logic {
    WR_SET = 1'b0,
    WR_OUT = 1'b1
  } wr_kind_e;
endpackage

// File: rtl/pinarb_mask.sv
module pinarb_mask #(
  parameter int NP = 32,
  parameter int IW = $clog2(NP),
  parameter int CW = IW + 1
) (
  input  logic [IW-1:0] base,
  input  logic [CW-1:0] count,
  output logic [NP-1:0] mask
);
  // contiguous run of count pins from base, wrapping modulo NP (NP power of two)
  always_comb begin
    mask = '0;
    for (int i = 0; i < NP; i++) begin
      logic [IW-1:0] pos;
      pos = IW'(i) + base;
      if (CW'(i) < count) mask[pos] = 1'b1;
    end
  end
endmodule

// File: rtl/pinarb_seq_front.sv
module pinarb_seq_front #(
  parameter int NP = 32,
  parameter int IW = $clog2(NP),
  parameter int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic          cfg_sticky,
  input  logic          cfg_inl_en,
  input  logic          cfg_side_dir,
  input  logic [IW-1:0] cfg_en_idx,
  input  logic          dw_valid,
  input  logic          dw_is_out,
  input  logic [IW-1:0] dw_base,
  input  logic [CW-1:0] dw_count,
  input  logic [NP-1:0] dw_data,
  input  logic          ss_valid,
  input  logic [IW-1:0] ss_base,
  input  logic [CW-1:0] ss_count,
  input  logic [NP-1:0] ss_data,
  output logic          dreq_vld,
  output logic [NP-1:0] dreq_mask,
  output logic [NP-1:0] dreq_data,
  output logic          sreq_vld,
  output logic [NP-1:0] sreq_mask,
  output logic [NP-1:0] sreq_data,
  output logic          side_dir
);
  logic          sticky_q, inl_q, sdir_q;
  logic [IW-1:0] idx_q;
  logic          stk_vld_q;
  logic [NP-1:0] stk_mask_q, stk_data_q;
  logic [NP-1:0] dmask, smask;
  logic          gated, fresh;

  pinarb_mask #(.NP(NP), .IW(IW), .CW(CW)) u_dmask (
    .base(dw_base), .count(dw_count), .mask(dmask));
  pinarb_mask #(.NP(NP), .IW(IW), .CW(CW)) u_smask (
    .base(ss_base), .count(ss_count), .mask(smask));

  assign gated = dw_valid && (dw_is_out == pinarb_pkg::WR_OUT) && inl_q && !dw_data[idx_q];
  assign fresh = dw_valid && !gated;

  always_comb begin
    dreq_vld  = 1'b0;
    dreq_mask = '0;
    dreq_data = '0;
    if (fresh) begin
      dreq_vld  = 1'b1;
      dreq_mask = dmask;
      dreq_data = dw_data;
    end else if (sticky_q && stk_vld_q) begin
      dreq_vld  = 1'b1;
      dreq_mask = stk_mask_q;
      dreq_data = stk_data_q;
    end
  end

  assign sreq_vld  = ss_valid;
  assign sreq_mask = smask;
  assign sreq_data = ss_data;
  assign side_dir  = sdir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q   <= 1'b0;
      inl_q      <= 1'b0;
      sdir_q     <= 1'b0;
      idx_q      <= '0;
      stk_vld_q  <= 1'b0;
      stk_mask_q <= '0;
      stk_data_q <= '0;
    end else if (cfg_load) begin
      sticky_q  <= cfg_sticky;
      inl_q     <= cfg_inl_en;
      sdir_q    <= cfg_side_dir;
      idx_q     <= cfg_en_idx;
      stk_vld_q <= 1'b0;
    end else if (sticky_q) begin
      if (fresh) begin
        stk_vld_q  <= 1'b1;
        stk_mask_q <= dmask;
        stk_data_q <= dw_data;
      end else if (gated) begin
        stk_vld_q <= 1'b0;
      end
    end
  end

  // R6
  sticky_replay_chk: assert property (@(posedge clk) disable iff (rst)
    (sticky_q && fresh && !cfg_load) |=>
      (dw_valid || (dreq_vld && dreq_data == $past(dw_data) && dreq_mask == $past(dmask))));

  // R7
  inline_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (gated && !(sticky_q && stk_vld_q)) |-> !dreq_vld);

  // R8
  sticky_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (gated && sticky_q && !cfg_load) |=> (!dreq_vld || fresh));
endmodule

// File: rtl/pinarb_merge.sv
module pinarb_merge #(
  parameter int NS = 4,
  parameter int NP = 32
) (
  input  logic [NS-1:0]         dv,
  input  logic [NS-1:0][NP-1:0] dm,
  input  logic [NS-1:0][NP-1:0] dd,
  input  logic [NS-1:0]         sv,
  input  logic [NS-1:0][NP-1:0] sm,
  input  logic [NS-1:0][NP-1:0] sd,
  input  logic [NS-1:0]         sdir,
  input  logic [NP-1:0]         cur_val,
  input  logic [NP-1:0]         cur_dir,
  output logic [NP-1:0]         nxt_val,
  output logic [NP-1:0]         nxt_dir
);
  // lowest sequencer applied first so later (higher) ones overwrite;
  // side-set applied after its own sequencer's data write
  always_comb begin
    nxt_val = cur_val;
    nxt_dir = cur_dir;
    for (int s = 0; s < NS; s++) begin
      if (dv[s]) nxt_val = (nxt_val & ~dm[s]) | (dd[s] & dm[s]);
      if (sv[s]) begin
        if (sdir[s]) nxt_dir = (nxt_dir & ~sm[s]) | (sd[s] & sm[s]);
        else         nxt_val = (nxt_val & ~sm[s]) | (sd[s] & sm[s]);
      end
    end
  end
endmodule

// File: rtl/pin_out_arbiter.sv
module pin_out_arbiter #(
  parameter int NS = pinarb_pkg::DEF_NUM_SEQ,
  parameter int NP = pinarb_pkg::DEF_NUM_PINS,
  localparam int IW = $clog2(NP),
  localparam int CW = IW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NS-1:0]    cfg_load,
  input  logic [NS-1:0]    cfg_sticky,
  input  logic [NS-1:0]    cfg_inl_en,
  input  logic [NS-1:0]    cfg_side_dir,
  input  logic [NS*IW-1:0] cfg_en_idx,
  input  logic [NS-1:0]    dw_valid,
  input  logic [NS-1:0]    dw_is_out,
  input  logic [NS*IW-1:0] dw_base,
  input  logic [NS*CW-1:0] dw_count,
  input  logic [NS*NP-1:0] dw_data,
  input  logic [NS-1:0]    ss_valid,
  input  logic [NS*IW-1:0] ss_base,
  input  logic [NS*CW-1:0] ss_count,
  input  logic [NS*NP-1:0] ss_data,
  output logic [NP-1:0]    pin_val,
  output logic [NP-1:0]    pin_dir
);
  logic [NS-1:0]         d_vld, s_vld, s_dir;
  logic [NS-1:0][NP-1:0] d_mask, d_data, s_mask, s_data;
  logic [NP-1:0]         nxt_val, nxt_dir;

  for (genvar s = 0; s < NS; s++) begin : g_seq
    pinarb_seq_front #(.NP(NP), .IW(IW), .CW(CW)) u_front (
      .clk          (clk),
      .rst          (rst),
      .cfg_load     (cfg_load[s]),
      .cfg_sticky   (cfg_sticky[s]),
      .cfg_inl_en   (cfg_inl_en[s]),
      .cfg_side_dir (cfg_side_dir[s]),
      .cfg_en_idx   (cfg_en_idx[s*IW +: IW]),
      .dw_valid     (dw_valid[s]),
      .dw_is_out    (dw_is_out[s]),
      .dw_base      (dw_base[s*IW +: IW]),
      .dw_count     (dw_count[s*CW +: CW]),
      .dw_data      (dw_data[s*NP +: NP]),
      .ss_valid     (ss_valid[s]),
      .ss_base      (ss_base[s*IW +: IW]),
      .ss_count     (ss_count[s*CW +: CW]),
      .ss_data      (ss_data[s*NP +: NP]),
      .dreq_vld     (d_vld[s]),
      .dreq_mask    (d_mask[s]),
      .dreq_data    (d_data[s]),
      .sreq_vld     (s_vld[s]),
      .sreq_mask    (s_mask[s]),
      .sreq_data    (s_data[s]),
      .side_dir     (s_dir[s])
    );
  end

  pinarb_merge #(.NS(NS), .NP(NP)) u_merge (
    .dv(d_vld), .dm(d_mask), .dd(d_data),
    .sv(s_vld), .sm(s_mask), .sd(s_data), .sdir(s_dir),
    .cur_val(pin_val), .cur_dir(pin_dir),
    .nxt_val(nxt_val), .nxt_dir(nxt_dir));

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_val <= '0;
      pin_dir <= '0;
    end else begin
      pin_val <= nxt_val;
      pin_dir <= nxt_dir;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pin_val == '0 && pin_dir == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (d_vld == '0 && s_vld == '0) |=> ($stable(pin_val) && $stable(pin_dir)));

  // R3
  top_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (d_vld[NS-1] && !(s_vld[NS-1] && !s_dir[NS-1])) |=>
      (((pin_val ^ $past(d_data[NS-1])) & $past(d_mask[NS-1])) == '0));
endmodule

// File: tb/pin_out_arbiter_test.sv
module pin_out_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NP = 32;
  localparam int IW = 5;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]    cfg_load, cfg_sticky, cfg_inl_en, cfg_side_dir;
  logic [NS*IW-1:0] cfg_en_idx;
  logic [NS-1:0]    dw_valid, dw_is_out, ss_valid;
  logic [NS*IW-1:0] dw_base, ss_base;
  logic [NS*CW-1:0] dw_count, ss_count;
  logic [NS*NP-1:0] dw_data, ss_data;
  logic [NP-1:0]    pin_val, pin_dir;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [NS-1:0]   m_sticky, m_inl, m_sdir, m_sv;
  logic [IW-1:0]   m_idx [NS];
  logic [NP-1:0]   m_sm [NS];
  logic [NP-1:0]   m_sd [NS];
  logic [NP-1:0]   e_val, e_dir;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_out_arbiter uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_sticky(cfg_sticky),
    .cfg_inl_en(cfg_inl_en), .cfg_side_dir(cfg_side_dir), .cfg_en_idx(cfg_en_idx),
    .dw_valid(dw_valid), .dw_is_out(dw_is_out), .dw_base(dw_base),
    .dw_count(dw_count), .dw_data(dw_data), .ss_valid(ss_valid),
    .ss_base(ss_base), .ss_count(ss_count), .ss_data(ss_data),
    .pin_val(pin_val), .pin_dir(pin_dir));

  function automatic logic [NP-1:0] run_mask(input logic [IW-1:0] b, input logic [CW-1:0] c);
    logic [NP-1:0] m = '0;
    for (int i = 0; i < NP; i++)
      if (i < int'(c)) m[(int'(b) + i) % NP] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cfg_load = '0; cfg_sticky = '0; cfg_inl_en = '0; cfg_side_dir = '0; cfg_en_idx = '0;
    dw_valid = '0; dw_is_out = '0; dw_base = '0; dw_count = '0; dw_data = '0;
    ss_valid = '0; ss_base = '0; ss_count = '0; ss_data = '0;
  endtask

  task automatic put_dw(input int s, input bit is_out, input int b, input int c, input logic [NP-1:0] d);
    dw_valid[s] = 1'b1; dw_is_out[s] = is_out;
    dw_base[s*IW +: IW] = IW'(b); dw_count[s*CW +: CW] = CW'(c); dw_data[s*NP +: NP] = d;
  endtask

  task automatic put_ss(input int s, input int b, input int c, input logic [NP-1:0] d);
    ss_valid[s] = 1'b1;
    ss_base[s*IW +: IW] = IW'(b); ss_count[s*CW +: CW] = CW'(c); ss_data[s*NP +: NP] = d;
  endtask

  task automatic put_cfg(input int s, input bit stk, input bit inl, input bit sdir, input int idx);
    cfg_load[s] = 1'b1; cfg_sticky[s] = stk; cfg_inl_en[s] = inl;
    cfg_side_dir[s] = sdir; cfg_en_idx[s*IW +: IW] = IW'(idx);
  endtask

  // advance model by one edge using the inputs now applied
  task automatic model_step();
    logic [NP-1:0] v = e_val;
    logic [NP-1:0] d = e_dir;
    for (int s = 0; s < NS; s++) begin
      logic [NP-1:0] dat  = dw_data[s*NP +: NP];
      logic [NP-1:0] dm   = run_mask(dw_base[s*IW +: IW], dw_count[s*CW +: CW]);
      logic [NP-1:0] sm   = run_mask(ss_base[s*IW +: IW], ss_count[s*CW +: CW]);
      logic [NP-1:0] sdat = ss_data[s*NP +: NP];
      bit drop = dw_valid[s] && dw_is_out[s] && m_inl[s] && !dat[m_idx[s]];
      bit acc  = dw_valid[s] && !drop;
      if (acc) v = (v & ~dm) | (dat & dm);
      else if (m_sticky[s] && m_sv[s]) v = (v & ~m_sm[s]) | (m_sd[s] & m_sm[s]);
      if (ss_valid[s]) begin
        if (m_sdir[s]) d = (d & ~sm) | (sdat & sm);
        else           v = (v & ~sm) | (sdat & sm);
      end
      if (cfg_load[s]) begin
        m_sticky[s] = cfg_sticky[s]; m_inl[s] = cfg_inl_en[s];
        m_sdir[s] = cfg_side_dir[s]; m_idx[s] = cfg_en_idx[s*IW +: IW]; m_sv[s] = 1'b0;
      end else if (m_sticky[s]) begin
        if (acc) begin m_sv[s] = 1'b1; m_sm[s] = dm; m_sd[s] = dat; end
        else if (drop) m_sv[s] = 1'b0;
      end
    end
    e_val = v; e_dir = d;
  endtask

  task automatic step(input string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check({req, " val"}, pin_val, e_val);
    check({req, " dir"}, pin_dir, e_dir);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    m_sticky = '0; m_inl = '0; m_sdir = '0; m_sv = '0;
    for (int s = 0; s < NS; s++) begin m_idx[s] = '0; m_sm[s] = '0; m_sd[s] = '0; end
    e_val = '0; e_dir = '0;
    // R1 reset state, with writes applied during reset
    put_dw(3, 0, 0, 32, '1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 val", pin_val, '0);
    check("R1 dir", pin_dir, '0);
    rst = 1'b0;
    idle();
    // R1 options at zero: OUT with bit0=0 still lands (inline off)
    put_dw(1, 1, 2, 1, 32'h0000_0004);
    step("R1");
    check("R1 inline off", pin_val, 32'h0000_0004);
    // R2 wrap and R10 one-edge latency
    put_dw(0, 0, 30, 4, '1);
    step("R10");
    check("R2 wrap", pin_val, 32'hC000_0007);
    put_dw(0, 0, 8, 0, '1);
    step("R2");
    check("R2 count0", pin_val, 32'hC000_0007);
    put_dw(2, 0, 5, 40, 32'h0);
    step("R2");
    check("R2 count>=32", pin_val, 32'h0);
    put_dw(0, 0, 8, 2, '1);
    step("R2");
    step("R2");
    check("R2 hold", pin_val, 32'h0000_0300);
    // R3 priority
    put_dw(1, 0, 16, 1, '1); put_dw(2, 0, 16, 1, '1); put_dw(3, 0, 16, 1, '0);
    put_dw(0, 0, 17, 1, '1);
    put_ss(1, 17, 1, '0);
    step("R3");
    check("R3 prio", pin_val & 32'h0003_0000, 32'h0);
    // R4 side over own data
    put_dw(2, 0, 20, 1, '0); put_ss(2, 20, 1, '1);
    step("R4");
    check("R4 side wins", pin_val & 32'h0010_0000, 32'h0010_0000);
    // R5 side to directions
    put_cfg(1, 0, 0, 1, 0);
    step("R9");
    put_ss(1, 3, 1, '1);
    step("R5");
    check("R5 dir", pin_dir, 32'h0000_0008);
    check("R5 val untouched", pin_val & 32'h8, 32'h0);
    // R6 sticky
    put_cfg(2, 1, 0, 0, 0);
    step("R9");
    put_dw(2, 0, 12, 1, '1); put_dw(1, 0, 13, 1, '1);
    step("R6");
    for (int k = 0; k < 3; k++) begin
      put_dw(0, 0, 12, 2, '0);
      step("R6");
      check("R6 sticky holds", pin_val & 32'h3000, 32'h1000);
    end
    // R7 inline enable on seq3, index 31
    put_cfg(3, 0, 1, 0, 31);
    step("R9");
    put_dw(3, 1, 24, 1, 32'h0100_0000);
    step("R7");
    check("R7 dropped", pin_val & 32'h0100_0000, 32'h0);
    put_dw(3, 1, 24, 1, 32'h8100_0000);
    step("R7");
    check("R7 enabled", pin_val & 32'h0100_0000, 32'h0100_0000);
    put_dw(3, 0, 25, 1, 32'h0200_0000);
    step("R7");
    check("R7 SET ignores", pin_val & 32'h0200_0000, 32'h0200_0000);
    // R8 and R9: reload seq2 sticky+inline, idx 0 (clears store)
    put_cfg(2, 1, 1, 0, 0);
    put_dw(2, 0, 12, 1, '0);
    step("R9");
    check("R9 old cfg used", pin_val & 32'h1000, 32'h0);
    put_dw(0, 0, 12, 1, '0);
    step("R9");
    put_dw(2, 1, 12, 1, 32'h0000_1001);
    step("R8");
    put_dw(0, 0, 12, 1, '0);
    step("R8");
    check("R8 sticky active", pin_val & 32'h1000, 32'h1000);
    put_dw(2, 1, 12, 1, 32'h0000_1000);
    step("R8");
    check("R8 cancel no write", pin_val & 32'h1000, 32'h1000);
    put_dw(0, 0, 12, 1, '0);
    step("R8");
    check("R8 shows through", pin_val & 32'h1000, 32'h0);
    // random mix against the model
    for (int n = 0; n < 600; n++) begin
      for (int s = 0; s < NS; s++) begin
        if (($urandom % 16) == 0)
          put_cfg(s, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 32);
        if (($urandom % 3) != 0)
          put_dw(s, $urandom % 2, $urandom % 32, $urandom % 41, $urandom);
        if (($urandom % 3) == 0)
          put_ss(s, $urandom % 32, $urandom % 6, $urandom);
      end
      step("R3 R6 R8 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule